// File: doc/BRIEF.md
# Single-Digit Decimal Adder with Folded Correction

This block adds two decimal digits, each coded as four-bit BCD, together with a carry from the digit below. It returns one BCD result digit and a decimal carry for the digit above. It has no registers. The result settles within the same cycle in which the operands are presented.

The datapath first forms the plain binary sum of the operands and the carry with one four-bit ripple adder. A detector then raises an adjust flag when that sum is too large for a decimal digit. A small set of gates applies the +6 adjustment directly to each sum bit. No second adder is used for the adjustment. The block is meant to be placed once per digit inside a wider decimal datapath. Operand codes 10 to 15 are outside its contract.

Top module: `bcd_digit_adder`

## Requirements
- R1: When a_dig + b_dig + c_in is 9 or less, sum_dig equals that total and c_out is 0.
- R2: When a_dig + b_dig + c_in lies in 10..19, sum_dig equals the total minus 10 and c_out is 1.
- R3: c_out is 1 exactly when a_dig + b_dig + c_in exceeds 9.
- R4: Bit 0 of sum_dig always equals a_dig[0] XOR b_dig[0] XOR c_in, because the adjustment never alters the least significant bit.
- R5: For every valid operand pair and carry, sum_dig is a valid BCD code, that is 9 or less.
- R6: At the decimal edges the results are as follows. 9+0 with carry 0 gives 9 and c_out 0. 9+0 with carry 1 gives 0 and c_out 1. 9+9 with carry 1 gives 9 and c_out 1. 0+0 with carry 0 gives 0 and c_out 0.
- R7: The outputs depend only on the present inputs, and settle without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dig | input | 4 | First BCD operand digit (0..9) |
| b_dig | input | 4 | Second BCD operand digit (0..9) |
| c_in | input | 1 | Carry from the lower decimal digit |
| sum_dig | output | 4 | BCD result digit |
| c_out | output | 1 | Decimal carry to the next digit |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the ports. The bench changes operands on a falling clock edge and reads sum_dig and c_out half a period later. The combinational paths are therefore settled when read, and no edge race is possible. The 200 valid operand and carry combinations are applied one per cycle. Each result is compared against an integer total split into a decimal digit and a carry.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  localparam int DIGIT_W   = 4;
  localparam int MAX_DIGIT = 9;
  localparam int RADIX     = MAX_DIGIT + 1;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_raw_adder.sv
module bcd_raw_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         ci,
  output logic [W-1:0] raw,
  output logic         co
);
  logic [W:0] chain;

  assign chain[0] = ci;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_fa
      assign raw[i]     = op_a[i] ^ op_b[i] ^ chain[i];
      assign chain[i+1] = (op_a[i] & op_b[i]) | (chain[i] & (op_a[i] ^ op_b[i]));
    end
  endgenerate

  assign co = chain[W];

  // R1 support: the ripple chain must equal the arithmetic total
  always_comb begin
    assert_raw_total_R1: assert ({co, raw} == ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, ci}));
  end
endmodule

// File: rtl/bcd_excess_detect.sv
module bcd_excess_detect
  import bcd_digit_pkg::*;
(
  input  digit_t raw,
  input  logic   co,
  output logic   adj
);
  // Over nine: binary carry, or 12..15, or 10..11
  assign adj = co | (raw[3] & raw[2]) | (raw[3] & raw[1]);

  always_comb begin
    assert_adj_flag_R3: assert (adj == ({co, raw} > 5'(MAX_DIGIT)));
  end
endmodule

// File: rtl/bcd_fold_correct.sv
module bcd_fold_correct
  import bcd_digit_pkg::*;
(
  input  digit_t raw,
  input  logic   adj,
  output digit_t fixed
);
  // +6 folded into per-bit gates
  assign fixed[0] = raw[0];
  assign fixed[1] = raw[1] ^ adj;
  assign fixed[2] = raw[2] ^ (adj & ~raw[1]);
  assign fixed[3] = raw[3] ^ (adj & (raw[1] | raw[2]));

  always_comb begin
    assert_pass_through_R1: assert (adj || (fixed == raw));
    assert_plus_six_R2: assert (!adj || (fixed == digit_t'(raw + 4'd6)));
  end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_digit_pkg::*;
(
  input  logic [3:0] a_dig,
  input  logic [3:0] b_dig,
  input  logic       c_in,
  output logic [3:0] sum_dig,
  output logic       c_out
);
  digit_t raw_s;
  logic   raw_co;
  logic   adj_s;
  digit_t fixed_s;

  bcd_raw_adder #(.W(DIGIT_W)) u_add (
    .op_a (a_dig),
    .op_b (b_dig),
    .ci   (c_in),
    .raw  (raw_s),
    .co   (raw_co)
  );

  bcd_excess_detect u_det (
    .raw (raw_s),
    .co  (raw_co),
    .adj (adj_s)
  );

  bcd_fold_correct u_fix (
    .raw   (raw_s),
    .adj   (adj_s),
    .fixed (fixed_s)
  );

  assign sum_dig = fixed_s;
  assign c_out   = adj_s;

  logic ops_ok;
  assign ops_ok = (a_dig <= 4'(MAX_DIGIT)) && (b_dig <= 4'(MAX_DIGIT));

  always_comb begin
    assert_digit_valid_R5: assert (!ops_ok || (sum_dig <= 4'(MAX_DIGIT)));
    assert_decimal_value_R2: assert (!ops_ok ||
      ((c_out ? 5'(RADIX) : 5'd0) + {1'b0, sum_dig} ==
       {1'b0, a_dig} + {1'b0, b_dig} + {4'd0, c_in}));
    assert_lsb_kept_R4: assert (sum_dig[0] == (a_dig[0] ^ b_dig[0] ^ c_in));
  end
endmodule

// File: tb/tb_bcd_digit_adder.sv
module tb_bcd_digit_adder;
  logic       clk;
  logic [3:0] a_dig, b_dig;
  logic       c_in;
  logic [3:0] sum_dig;
  logic       c_out;
  int         n_checks;
  int         n_fail;
  int         cyc;
  bit         done;

  bcd_digit_adder dut (
    .a_dig   (a_dig),
    .b_dig   (b_dig),
    .c_in    (c_in),
    .sum_dig (sum_dig),
    .c_out   (c_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    cyc  = 0;
    done = 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected finish before 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d ci=%0d actual %0d expected %0d",
               tag, a_dig, b_dig, c_in, got, exp);
    end
  endtask

  // drive on falling edge, sample half period later
  task automatic apply(input int a, input int b, input int ci);
    @(negedge clk);
    a_dig = 4'(a);
    b_dig = 4'(b);
    c_in  = ci[0];
    @(posedge clk);
    #1;
  endtask

  task automatic t_idle_zero();
    apply(0, 0, 0);
    chk("R6 zero sum", int'(sum_dig), 0);
    chk("R6 zero carry", int'(c_out), 0);
  endtask

  task automatic t_exhaustive();
    for (int a = 0; a <= 9; a++)
      for (int b = 0; b <= 9; b++)
        for (int ci = 0; ci <= 1; ci++) begin
          int tot;
          apply(a, b, ci);
          tot = a + b + ci;
          if (tot <= 9) begin
            chk("R1 sum", int'(sum_dig), tot);
            chk("R1 carry", int'(c_out), 0);
          end else begin
            chk("R2 sum", int'(sum_dig), tot - 10);
          end
          chk("R3 carry", int'(c_out), (tot > 9) ? 1 : 0);
          chk("R4 lsb", int'(sum_dig[0]), (a ^ b ^ ci) & 1);
          chk("R5 valid", (sum_dig <= 4'd9) ? 1 : 0, 1);
        end
  endtask

  task automatic t_edges();
    apply(9, 0, 0);
    chk("R6 9+0+0 sum", int'(sum_dig), 9);
    chk("R6 9+0+0 carry", int'(c_out), 0);
    apply(9, 0, 1);
    chk("R6 9+0+1 sum", int'(sum_dig), 0);
    chk("R6 9+0+1 carry", int'(c_out), 1);
    apply(9, 9, 1);
    chk("R6 9+9+1 sum", int'(sum_dig), 9);
    chk("R6 9+9+1 carry", int'(c_out), 1);
    apply(5, 5, 0);
    chk("R6 5+5 sum", int'(sum_dig), 0);
    chk("R6 5+5 carry", int'(c_out), 1);
  endtask

  // R7: outputs follow inputs with no clock edge in between
  task automatic t_no_clock();
    @(negedge clk);
    a_dig = 4'd7; b_dig = 4'd8; c_in = 1'b0;
    #1;
    chk("R7 sum before edge", int'(sum_dig), 5);
    chk("R7 carry before edge", int'(c_out), 1);
    a_dig = 4'd2; b_dig = 4'd3; c_in = 1'b1;
    #1;
    chk("R7 sum follows", int'(sum_dig), 6);
    chk("R7 carry follows", int'(c_out), 0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    a_dig = 4'd0; b_dig = 4'd0; c_in = 1'b0;
    t_idle_zero();
    t_exhaustive();
    t_edges();
    t_no_clock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule